// File: doc/BRIEF.md
# Tagged Reservation Table with Oldest-First Select

This block is one node table of an out-of-order execution core. A merger writes operations into it one per cycle. Each operation carries a node index, an opcode, a priority flag and two source operands. A source is either a literal value, which is ready at once, or a pending producer tag. Results come back on two distribution ports as tag/value pairs. Each pending source whose tag matches captures the value and becomes ready.

Each cycle the table picks one entry whose two sources are both ready and sends it to the function unit. Entries flagged high priority go first. Among equals, the one merged earliest goes first, and the issued entry leaves the table. A repair request names a node index and removes every entry merged after it. The table also reports the node index of its oldest remaining entry, so that retirement logic can decide how far the machine may commit.

Top module: `rtab_table`

## Requirements
- R1: After reset the table is empty: `full`, `issue_valid` and `oldest_valid` are 0.
- R2: A merge is accepted when `merge_valid` is 1, `full` is 0 and `repair_valid` is 0. The new entry can issue at the earliest in the next cycle.
- R3: A source with its literal flag set is stored ready, holding the given value, and its tag input is ignored.
- R4: A pending source whose tag equals the tag on a valid distribution port captures that port's value at the clock edge and is ready from the next cycle. When both ports carry the matching tag, port 0 supplies the value. Port p occupies `dist_tag[6p+5:6p]` and `dist_val[32p+31:32p]`.
- R5: A pending source whose tag is broadcast in the same cycle it is merged is stored ready with the broadcast value.
- R6: When any entry has both sources ready, `issue_valid` is 1 and the oldest such entry by merge order is presented. At most one entry issues per cycle, and the issued entry is removed.
- R7: Among ready entries, those merged with `merge_prio` set are issued before any entry without it. Merge order decides within each group.
- R8: `full` is 1 when all 8 entries are occupied, and a merge presented while full is refused and never issues.
- R9: In a cycle with `repair_valid`, every entry whose index n satisfies (n - `repair_idx`) mod 64 in 1..31 is removed. In that same cycle no merge is accepted and `issue_valid` is 0.
- R10: `oldest_valid` is 1 when any entry is held, and `oldest_idx` then gives the node index of the earliest merged entry still present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| merge_valid | input | 1 | Merge request |
| merge_idx | input | 6 | Node index of the merged operation |
| merge_op | input | 8 | Opcode passed through to issue |
| merge_prio | input | 1 | High-priority flag |
| merge_a_lit | input | 1 | Source A is a literal |
| merge_a_tag | input | 6 | Source A producer tag |
| merge_a_val | input | 32 | Source A literal value |
| merge_b_lit | input | 1 | Source B is a literal |
| merge_b_tag | input | 6 | Source B producer tag |
| merge_b_val | input | 32 | Source B literal value |
| full | output | 1 | No free entry |
| dist_valid | input | 2 | Per-port result valid |
| dist_tag | input | 12 | Per-port result tag |
| dist_val | input | 64 | Per-port result value |
| repair_valid | input | 1 | Back-up request |
| repair_idx | input | 6 | Last node index that survives the back-up |
| issue_valid | output | 1 | An entry is issued this cycle |
| issue_idx | output | 6 | Node index of the issued entry |
| issue_op | output | 8 | Opcode of the issued entry |
| issue_a | output | 32 | Source A value |
| issue_b | output | 32 | Source B value |
| oldest_valid | output | 1 | Table holds at least one entry |
| oldest_idx | output | 6 | Node index of the oldest held entry |

## Verification
The hardest case to reach is a repair that lands while a ready entry younger than the repair point is about to issue. Because the function unit never stalls, a ready entry leaves the table on the very next edge. The stimulus sets this up by releasing two waiting entries with a single broadcast. The older one issues in the following cycle, and the repair is driven in the cycle after that, exactly when the younger one would go. The same approach reaches the ordering and priority cases: several entries wait on one tag, so that they all become ready together. Repair is also tested with node indices that wrap past 63.

// File: rtl/rtab_pkg.sv
package rtab_pkg;
    localparam int IDX_W      = 6;
    localparam int VAL_W      = 32;
    localparam int OP_W       = 8;
    localparam int DIST_PORTS = 2;

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [VAL_W-1:0] val_t;

    typedef struct packed {
        logic rdy;
        idx_t tag;
        val_t val;
    } src_t;

    typedef struct packed {
        logic            vld;
        logic            prio;
        idx_t            idx;
        logic [OP_W-1:0] op;
        src_t            a;
        src_t            b;
    } ent_t;

    // Node is later than the reference point within a half-window of the index space.
    function automatic logic younger_than(idx_t node, idx_t rp);
        idx_t d;
        d = node - rp;
        return (d != '0) && !d[IDX_W-1];
    endfunction

    // Capture a broadcast result; the lowest numbered matching port wins.
    function automatic src_t snoop(src_t s, logic [DIST_PORTS-1:0] v,
                                   idx_t [DIST_PORTS-1:0] t, val_t [DIST_PORTS-1:0] x);
        src_t r;
        r = s;
        for (int p = DIST_PORTS - 1; p >= 0; p--) begin
            if (!s.rdy && v[p] && (t[p] == s.tag)) begin
                r.rdy = 1'b1;
                r.val = x[p];
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/rtab_pick.sv
// Grants the request with no older requester, given an age matrix where
// older[j][i] means entry j was merged before entry i.
module rtab_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0]        req,
    input  logic [N-1:0][N-1:0] older,
    output logic [N-1:0]        gnt
);
    for (genvar i = 0; i < N; i++) begin : g_col
        logic [N-1:0] col;
        always_comb begin
            for (int j = 0; j < N; j++) col[j] = older[j][i];
        end
        assign gnt[i] = req[i] && ((req & col) == '0);
    end
endmodule

// File: rtl/rtab_free.sv
module rtab_free #(
    parameter int N  = 8,
    localparam int SW = $clog2(N)
) (
    input  logic [N-1:0]  vld,
    output logic [SW-1:0] slot,
    output logic          none_free
);
    always_comb begin
        slot      = '0;
        none_free = 1'b1;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                slot      = SW'(i);
                none_free = 1'b0;
            end
        end
    end
endmodule

// File: rtl/rtab_table.sv
module rtab_table
    import rtab_pkg::*;
#(
    parameter int N = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        merge_valid,
    input  logic [IDX_W-1:0]            merge_idx,
    input  logic [OP_W-1:0]             merge_op,
    input  logic                        merge_prio,
    input  logic                        merge_a_lit,
    input  logic [IDX_W-1:0]            merge_a_tag,
    input  logic [VAL_W-1:0]            merge_a_val,
    input  logic                        merge_b_lit,
    input  logic [IDX_W-1:0]            merge_b_tag,
    input  logic [VAL_W-1:0]            merge_b_val,
    output logic                        full,
    input  logic [DIST_PORTS-1:0]       dist_valid,
    input  logic [DIST_PORTS*IDX_W-1:0] dist_tag,
    input  logic [DIST_PORTS*VAL_W-1:0] dist_val,
    input  logic                        repair_valid,
    input  logic [IDX_W-1:0]            repair_idx,
    output logic                        issue_valid,
    output logic [IDX_W-1:0]            issue_idx,
    output logic [OP_W-1:0]             issue_op,
    output logic [VAL_W-1:0]            issue_a,
    output logic [VAL_W-1:0]            issue_b,
    output logic                        oldest_valid,
    output logic [IDX_W-1:0]            oldest_idx
);
    localparam int SW = $clog2(N);

    typedef struct packed {
        ent_t [N-1:0]        ent;
        logic [N-1:0][N-1:0] older;
    } state_t;

    state_t s_q, s_d;

    idx_t [DIST_PORTS-1:0] dtag;
    val_t [DIST_PORTS-1:0] dval;
    always_comb begin
        for (int p = 0; p < DIST_PORTS; p++) begin
            dtag[p] = dist_tag[p*IDX_W +: IDX_W];
            dval[p] = dist_val[p*VAL_W +: VAL_W];
        end
    end

    logic [N-1:0] vld_q, rdy_q, hot_q, req_iss, gnt_iss, gnt_old;
    always_comb begin
        for (int i = 0; i < N; i++) begin
            vld_q[i] = s_q.ent[i].vld;
            rdy_q[i] = s_q.ent[i].vld && s_q.ent[i].a.rdy && s_q.ent[i].b.rdy;
            hot_q[i] = rdy_q[i] && s_q.ent[i].prio;
        end
        req_iss = (hot_q != '0) ? hot_q : rdy_q;
    end

    rtab_pick #(.N(N)) u_pick_issue  (.req(req_iss), .older(s_q.older), .gnt(gnt_iss));
    rtab_pick #(.N(N)) u_pick_oldest (.req(vld_q),   .older(s_q.older), .gnt(gnt_old));

    logic [SW-1:0] free_slot;
    logic          none_free;
    rtab_free #(.N(N)) u_free (.vld(vld_q), .slot(free_slot), .none_free(none_free));

    logic          accept;
    logic [SW-1:0] iss_slot;
    assign full         = none_free;
    assign accept       = merge_valid && !none_free && !repair_valid;
    assign issue_valid  = (gnt_iss != '0) && !repair_valid;
    assign oldest_valid = (vld_q != '0);

    always_comb begin
        iss_slot   = '0;
        issue_idx  = '0;
        issue_op   = '0;
        issue_a    = '0;
        issue_b    = '0;
        oldest_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt_iss[i]) begin
                iss_slot  = SW'(i);
                issue_idx = s_q.ent[i].idx;
                issue_op  = s_q.ent[i].op;
                issue_a   = s_q.ent[i].a.val;
                issue_b   = s_q.ent[i].b.val;
            end
            if (gnt_old[i]) oldest_idx = s_q.ent[i].idx;
        end
    end

    ent_t new_ent;
    always_comb begin
        new_ent       = '0;
        new_ent.vld   = 1'b1;
        new_ent.prio  = merge_prio;
        new_ent.idx   = merge_idx;
        new_ent.op    = merge_op;
        new_ent.a.rdy = merge_a_lit;
        new_ent.a.tag = merge_a_lit ? '0 : merge_a_tag;
        new_ent.a.val = merge_a_lit ? merge_a_val : '0;
        new_ent.b.rdy = merge_b_lit;
        new_ent.b.tag = merge_b_lit ? '0 : merge_b_tag;
        new_ent.b.val = merge_b_lit ? merge_b_val : '0;
        new_ent.a     = snoop(new_ent.a, dist_valid, dtag, dval);
        new_ent.b     = snoop(new_ent.b, dist_valid, dtag, dval);
    end

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < N; i++) begin
            s_d.ent[i].a = snoop(s_q.ent[i].a, dist_valid, dtag, dval);
            s_d.ent[i].b = snoop(s_q.ent[i].b, dist_valid, dtag, dval);
            if (issue_valid && gnt_iss[i]) s_d.ent[i].vld = 1'b0;
            if (repair_valid && younger_than(s_q.ent[i].idx, repair_idx)) s_d.ent[i].vld = 1'b0;
        end
        if (accept) begin
            s_d.ent[free_slot] = new_ent;
            for (int j = 0; j < N; j++) begin
                s_d.older[free_slot][j] = 1'b0;
                s_d.older[j][free_slot] = (j != int'(free_slot));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2: an accepted merge grows the table by one, less any issue in the same cycle
    a_r2_merge_adds: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> $countones(vld_q) == $past($countones(vld_q)) + 1 - 32'($past(issue_valid)));

    // R8: a merge presented while full adds nothing
    a_r8_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (merge_valid && full) |=> $countones(vld_q) <= $past($countones(vld_q)));

    // R6: at most one grant, and the granted entry is gone after the edge
    a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_iss));
    a_r6_issued_removed: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> !vld_q[$past(iss_slot)]);

    // R9: nothing later than the repair point survives
    for (genvar g = 0; g < N; g++) begin : g_chk
        a_r9_repair_clears: assert property (@(posedge clk) disable iff (!rst_n)
            repair_valid |=> !(s_q.ent[g].vld && younger_than(s_q.ent[g].idx, $past(repair_idx))));
    end
endmodule

// File: tb/rtab_table_test.sv
module rtab_table_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        merge_valid = 1'b0;
    logic [5:0]  merge_idx = '0;
    logic [7:0]  merge_op = '0;
    logic        merge_prio = 1'b0;
    logic        merge_a_lit = 1'b0;
    logic [5:0]  merge_a_tag = '0;
    logic [31:0] merge_a_val = '0;
    logic        merge_b_lit = 1'b0;
    logic [5:0]  merge_b_tag = '0;
    logic [31:0] merge_b_val = '0;
    logic        full;
    logic [1:0]  dist_valid = '0;
    logic [11:0] dist_tag = '0;
    logic [63:0] dist_val = '0;
    logic        repair_valid = 1'b0;
    logic [5:0]  repair_idx = '0;
    logic        issue_valid;
    logic [5:0]  issue_idx;
    logic [7:0]  issue_op;
    logic [31:0] issue_a, issue_b;
    logic        oldest_valid;
    logic [5:0]  oldest_idx;

    rtab_table uut (
        .clk(clk), .rst_n(rst_n),
        .merge_valid(merge_valid), .merge_idx(merge_idx), .merge_op(merge_op),
        .merge_prio(merge_prio), .merge_a_lit(merge_a_lit), .merge_a_tag(merge_a_tag),
        .merge_a_val(merge_a_val), .merge_b_lit(merge_b_lit), .merge_b_tag(merge_b_tag),
        .merge_b_val(merge_b_val), .full(full),
        .dist_valid(dist_valid), .dist_tag(dist_tag), .dist_val(dist_val),
        .repair_valid(repair_valid), .repair_idx(repair_idx),
        .issue_valid(issue_valid), .issue_idx(issue_idx), .issue_op(issue_op),
        .issue_a(issue_a), .issue_b(issue_b),
        .oldest_valid(oldest_valid), .oldest_idx(oldest_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [5:0]  idx;
        logic [31:0] a;
        logic [31:0] b;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    function automatic logic [7:0] opf(logic [5:0] i);
        return {2'b00, i} ^ 8'h5A;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic expect_issue(logic [5:0] i, logic [31:0] a, logic [31:0] b, string req);
        exp_t e;
        e.idx = i; e.a = a; e.b = b; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic merge(logic [5:0] i, logic p, logic al, logic [5:0] at, logic [31:0] av,
                         logic bl, logic [5:0] bt, logic [31:0] bv);
        merge_valid = 1'b1; merge_idx = i; merge_op = opf(i); merge_prio = p;
        merge_a_lit = al; merge_a_tag = at; merge_a_val = av;
        merge_b_lit = bl; merge_b_tag = bt; merge_b_val = bv;
    endtask

    task automatic bcast(int p, logic [5:0] t, logic [31:0] v);
        dist_valid[p] = 1'b1;
        dist_tag[p*6 +: 6] = t;
        dist_val[p*32 +: 32] = v;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        merge_valid = 1'b0; merge_prio = 1'b0; dist_valid = '0; repair_valid = 1'b0;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Monitor: sample just before the edge at which an issue takes effect
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (rst_n && issue_valid) begin
                if (exp_q.size() == 0) begin
                    check(0, "R6", "unexpected issue idx", int'(issue_idx), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(issue_idx == e.idx, e.req, "issue_idx", int'(issue_idx), int'(e.idx));
                    check(issue_op == opf(e.idx), e.req, "issue_op", int'(issue_op), int'(opf(e.idx)));
                    check(issue_a == e.a, e.req, "issue_a", int'(issue_a), int'(e.a));
                    check(issue_b == e.b, e.req, "issue_b", int'(issue_b), int'(e.b));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(0, "R6", "watchdog expired cycles", 20000, 0);
            finish_run();
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        #2;
        // R1: empty after reset
        check(full == 1'b0, "R1", "full", int'(full), 0);
        check(issue_valid == 1'b0, "R1", "issue_valid", int'(issue_valid), 0);
        check(oldest_valid == 1'b0, "R1", "oldest_valid", int'(oldest_valid), 0);
        step();

        // R2 R3: two literals, tags on the literal sources must be ignored
        expect_issue(6'd1, 32'd5, 32'd7, "R3");
        merge(6'd1, 1'b0, 1'b1, 6'd40, 32'd5, 1'b1, 6'd41, 32'd7);
        step();
        idle(2);

        // R4: capture on port 1
        merge(6'd2, 1'b0, 1'b0, 6'd40, 32'd0, 1'b1, 6'd0, 32'd9);
        step();
        idle(2);
        expect_issue(6'd2, 32'h1234, 32'd9, "R4");
        bcast(1, 6'd40, 32'h1234);
        step();
        idle(2);

        // R4: both ports match, port 0 supplies the value
        merge(6'd24, 1'b0, 1'b0, 6'd48, 32'd0, 1'b1, 6'd0, 32'd3);
        step();
        expect_issue(6'd24, 32'hAAAA, 32'd3, "R4");
        bcast(0, 6'd48, 32'hAAAA);
        bcast(1, 6'd48, 32'hBBBB);
        step();
        idle(2);

        // R5: both tags broadcast in the merge cycle
        expect_issue(6'd3, 32'd11, 32'd22, "R5");
        merge(6'd3, 1'b0, 1'b0, 6'd41, 32'd0, 1'b0, 6'd42, 32'd0);
        bcast(0, 6'd41, 32'd11);
        bcast(1, 6'd42, 32'd22);
        step();
        idle(2);

        // R6 R10: three entries released together issue oldest first
        for (int i = 4; i <= 6; i++) begin
            merge(6'(i), 1'b0, 1'b0, 6'd43, 32'd0, 1'b1, 6'd0, 32'(i));
            step();
        end
        check(oldest_valid && oldest_idx == 6'd4, "R10", "oldest_idx", int'(oldest_idx), 4);
        for (int i = 4; i <= 6; i++) expect_issue(6'(i), 32'd100, 32'(i), "R6");
        bcast(0, 6'd43, 32'd100);
        step();
        idle(4);

        // R7: the flagged entry jumps the queue
        for (int i = 7; i <= 9; i++) begin
            merge(6'(i), (i == 8), 1'b0, 6'd44, 32'd0, 1'b1, 6'd0, 32'(i));
            step();
        end
        expect_issue(6'd8, 32'd200, 32'd8, "R7");
        expect_issue(6'd7, 32'd200, 32'd7, "R7");
        expect_issue(6'd9, 32'd200, 32'd9, "R7");
        bcast(0, 6'd44, 32'd200);
        step();
        idle(4);

        // R8: fill, refuse a ready merge, then drain
        for (int i = 10; i <= 17; i++) begin
            merge(6'(i), 1'b0, 1'b0, 6'd45, 32'd0, 1'b1, 6'd0, 32'(i));
            step();
        end
        check(full == 1'b1, "R8", "full after 8 merges", int'(full), 1);
        merge(6'd18, 1'b0, 1'b1, 6'd0, 32'd1, 1'b1, 6'd0, 32'd2);
        step();
        check(full == 1'b1, "R8", "full after refused merge", int'(full), 1);
        check(oldest_idx == 6'd10, "R8", "oldest_idx when full", int'(oldest_idx), 10);
        for (int i = 10; i <= 17; i++) expect_issue(6'(i), 32'd300, 32'(i), "R8");
        bcast(1, 6'd45, 32'd300);
        step();
        idle(10);
        check(full == 1'b0, "R8", "full after drain", int'(full), 0);
        check(oldest_valid == 1'b0, "R10", "oldest_valid after drain", int'(oldest_valid), 0);

        // R9: repair across the index wrap
        merge(6'd62, 1'b0, 1'b0, 6'd46, 32'd0, 1'b1, 6'd0, 32'd62); step();
        merge(6'd63, 1'b0, 1'b0, 6'd46, 32'd0, 1'b1, 6'd0, 32'd63); step();
        merge(6'd0,  1'b0, 1'b0, 6'd46, 32'd0, 1'b1, 6'd0, 32'd0);  step();
        merge(6'd1,  1'b0, 1'b0, 6'd46, 32'd0, 1'b1, 6'd0, 32'd1);  step();
        repair_valid = 1'b1; repair_idx = 6'd63;
        step();
        check(oldest_valid && oldest_idx == 6'd62, "R9", "oldest_idx after repair", int'(oldest_idx), 62);
        expect_issue(6'd62, 32'd400, 32'd62, "R9");
        expect_issue(6'd63, 32'd400, 32'd63, "R9");
        bcast(0, 6'd46, 32'd400);
        step();
        idle(4);
        check(oldest_valid == 1'b0, "R9", "oldest_valid after wrap drain", int'(oldest_valid), 0);

        // R9: repair in the cycle a younger ready entry would issue; merge refused too
        merge(6'd30, 1'b0, 1'b0, 6'd47, 32'd0, 1'b1, 6'd0, 32'd30); step();
        merge(6'd31, 1'b0, 1'b0, 6'd47, 32'd0, 1'b1, 6'd0, 32'd31); step();
        expect_issue(6'd30, 32'd500, 32'd30, "R9");
        bcast(0, 6'd47, 32'd500);
        step();
        step();
        repair_valid = 1'b1; repair_idx = 6'd30;
        merge(6'd32, 1'b0, 1'b1, 6'd0, 32'd1, 1'b1, 6'd0, 32'd1);
        #2;
        check(issue_valid == 1'b0, "R9", "issue_valid during repair", int'(issue_valid), 0);
        step();
        idle(4);
        check(oldest_valid == 1'b0, "R9", "oldest_valid after repair", int'(oldest_valid), 0);

        check(exp_q.size() == 0, "R6", "expected issues left over", exp_q.size(), 0);
        done = 1;
        finish_run();
    end
endmodule